// File: doc/BRIEF.md
# Tick-Driven Divider Timer with Masked Interrupts

This block is a small timer on a 4-bit register bus. A free-running 8-bit binary counter advances once per 256 Hz tick enable, so its bits divide the tick down into a ladder of frequencies from 128 Hz (bit 0) to 1 Hz (bit 7). Software reads the counter as two nibble registers and can zero it through a write-one control bit.

Four of the counter bits (the 32, 8, 2 and 1 Hz taps) are interrupt sources. When one of these taps falls from 1 to 0 on an advance, a sticky cause flag is set, whether or not the source is enabled. Reading the cause register returns the flags and clears them. An enable register picks which flags drive the single interrupt request line.

The register map is: offset 0 cause flags (read, clear on read), offset 1 enable mask (read/write), offset 2 counter low nibble (read only), offset 3 counter high nibble (read only), offset 4 control (write only, bit 0 clears the counter). Each bus cycle is decoded into one of four access kinds: IDLE (no strobe), READ, WRITE, or READ_WRITE (both strobes in the same cycle, where each acts on its own). Every cycle starts again from IDLE; there is no multi-cycle sequence.

Top module: `ctmr_top`

## Requirements
- R1: After reset the counter is 0, all four cause flags are 0, all four enable bits are 0 and `irq` is low.
- R2: Each cycle with `tick` high and no counter clear adds one to the counter, wrapping from 255 to 0; without a tick it holds. Offset 2 reads counter bits 3:0 (bit 0 = 128 Hz, bit 3 = 16 Hz) and offset 3 reads bits 7:4 (bit 0 = 8 Hz, bit 3 = 1 Hz).
- R3: A write to offset 4 with data bit 0 set zeroes the counter at that edge, even if `tick` is high in the same cycle; writing 0 to that bit does nothing. Zeroing the counter sets no cause flag.
- R4: A read of offset 4 returns 0.
- R5: Writes to offsets 2 and 3 do not change the counter.
- R6: A cause flag is set when its tap changes from 1 to 0 on an advance: flag bit 0 follows counter bit 2 (32 Hz), bit 1 counter bit 4 (8 Hz), bit 2 counter bit 6 (2 Hz), bit 3 counter bit 7 (1 Hz). Flags are set regardless of the enable bits and stay set until read.
- R7: A read of offset 0 returns the flags present before the edge and clears them at that edge; a tap fall arriving in the same cycle leaves its flag set.
- R8: Offset 1 holds the enable bits in the same bit order as the flags; 1 enables a source. It reads back what was written and changes only on a write to offset 1.
- R9: `irq` is high exactly when some flag is set and its enable bit is 1.
- R10: Offsets 5 to 15 read as 0 and writes to them change nothing; `rdata` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 256 Hz advance enable, one cycle wide |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, valid in the cycle of `rd_en` |
| irq | output | 1 | Interrupt request, high while an enabled flag is set |

## Verification
The hardest case to reach from the ports is a cause-register read landing in the very cycle in which a tap falls, since only then does the clear-on-read compete with a new flag. The stimulus clears the counter, steps it with single ticks to 7, one count short of the 32 Hz tap falling, and then issues the tick together with the cause read. The reference model in the bench predicts both the returned value and the flag left behind, and a long run of mixed ticks and reads also sweeps the 1 Hz tap through its wrap from 255 to 0.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CNT_W  = 8;
    localparam int NIB_W  = 4;
    localparam int OFS_W  = 4;
    localparam int SRC_N  = 4;
    localparam int CLR_BIT = 0;

    typedef enum logic [3:0] {
        OFS_CAUSE = 4'd0,
        OFS_ENA   = 4'd1,
        OFS_CLO   = 4'd2,
        OFS_CHI   = 4'd3,
        OFS_CTRL  = 4'd4
    } reg_ofs_e;

    typedef enum logic [1:0] {
        ACC_IDLE       = 2'd0,
        ACC_READ       = 2'd1,
        ACC_WRITE      = 2'd2,
        ACC_READ_WRITE = 2'd3
    } acc_kind_e;

    // counter bit that feeds interrupt source k
    function automatic int src_tap(input int k);
        case (k)
            0:       return 2;
            1:       return 4;
            2:       return 6;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/ctmr_divider.sv
module ctmr_divider
    import ctmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         clear,
    output logic [W-1:0] cnt,
    output logic [W-1:0] fall
);

    logic [W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt + W'(1);
    end

    // a bit falls when it is 1 now and 0 after the advance; a clear never counts
    always_comb begin
        if (advance && !clear) begin
            fall = cnt & ~cnt_inc;
        end else begin
            fall = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= cnt_inc;
        end
    end

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (cnt == W'($past(cnt) + W'(1))))
        else $error("counter did not advance by one");

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(cnt))
        else $error("counter moved without a tick");

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0))
        else $error("counter not zero after clear");

endmodule

// File: rtl/ctmr_irq.sv
module ctmr_irq
    import ctmr_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fall,
    input  logic         rd_clear,
    input  logic         ena_we,
    input  logic [N-1:0] ena_wdata,
    output logic [N-1:0] cause,
    output logic [N-1:0] ena,
    output logic         irq
);

    logic [N-1:0] src_edge;

    for (genvar k = 0; k < N; k++) begin : g_src
        assign src_edge[k] = fall[src_tap(k)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause <= '0;
        end else if (rd_clear) begin
            cause <= src_edge;
        end else begin
            cause <= cause | src_edge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena <= '0;
        end else if (ena_we) begin
            ena <= ena_wdata;
        end
    end

    always_comb begin
        irq = |(cause & ena);
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clear |=> ((cause & $past(cause)) == $past(cause)))
        else $error("cause flag lost without a read");

    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && (src_edge == '0)) |=> (cause == '0))
        else $error("cause flags not cleared by read");

    p_ena_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_we |=> $stable(ena))
        else $error("enable bits changed without a write");

endmodule

// File: rtl/ctmr_regif.sv
module ctmr_regif
    import ctmr_pkg::*;
#(
    parameter int AW = OFS_W,
    parameter int DW = NIB_W,
    parameter int W  = CNT_W,
    parameter int N  = SRC_N
) (
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [W-1:0]  cnt,
    input  logic [N-1:0]  cause,
    input  logic [N-1:0]  ena,
    output logic [DW-1:0] rdata,
    output logic          rd_clear,
    output logic          ena_we,
    output logic [N-1:0]  ena_wdata,
    output logic          cnt_clear
);

    acc_kind_e acc;
    logic      do_rd;
    logic      do_wr;
    logic [DW-1:0] rmux;

    always_comb begin
        acc = acc_kind_e'({wr_en, rd_en});
    end

    always_comb begin
        do_rd = 1'b0;
        do_wr = 1'b0;
        unique case (acc)
            ACC_IDLE:       begin do_rd = 1'b0; do_wr = 1'b0; end
            ACC_READ:       begin do_rd = 1'b1; do_wr = 1'b0; end
            ACC_WRITE:      begin do_rd = 1'b0; do_wr = 1'b1; end
            ACC_READ_WRITE: begin do_rd = 1'b1; do_wr = 1'b1; end
        endcase
    end

    always_comb begin
        rmux = '0;
        case (addr)
            AW'(OFS_CAUSE): rmux = DW'(cause);
            AW'(OFS_ENA):   rmux = DW'(ena);
            AW'(OFS_CLO):   rmux = cnt[DW-1:0];
            AW'(OFS_CHI):   rmux = cnt[2*DW-1:DW];
            default:        rmux = '0;
        endcase
        rdata = do_rd ? rmux : '0;
    end

    always_comb begin
        rd_clear  = do_rd && (addr == AW'(OFS_CAUSE));
        ena_we    = do_wr && (addr == AW'(OFS_ENA));
        ena_wdata = wdata[N-1:0];
        cnt_clear = do_wr && (addr == AW'(OFS_CTRL)) && wdata[CLR_BIT];
    end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int AW = OFS_W,
    parameter int DW = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);

    localparam int W = 2 * DW;
    localparam int N = SRC_N;

    logic [W-1:0] cnt;
    logic [W-1:0] fall;
    logic [N-1:0] cause;
    logic [N-1:0] ena;
    logic [N-1:0] ena_wdata;
    logic         rd_clear;
    logic         ena_we;
    logic         cnt_clear;

    ctmr_divider #(.W(W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (tick),
        .clear   (cnt_clear),
        .cnt     (cnt),
        .fall    (fall)
    );

    ctmr_irq #(.W(W), .N(N)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .rd_clear  (rd_clear),
        .ena_we    (ena_we),
        .ena_wdata (ena_wdata),
        .cause     (cause),
        .ena       (ena),
        .irq       (irq)
    );

    ctmr_regif #(.AW(AW), .DW(DW), .W(W), .N(N)) u_regif (
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cnt       (cnt),
        .cause     (cause),
        .ena       (ena),
        .rdata     (rdata),
        .rd_clear  (rd_clear),
        .ena_we    (ena_we),
        .ena_wdata (ena_wdata),
        .cnt_clear (cnt_clear)
    );

    p_data_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick && (addr == AW'(OFS_CLO) || addr == AW'(OFS_CHI))) |=> $stable(cnt))
        else $error("write to counter nibble changed the counter");

    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick && (addr > AW'(OFS_CTRL))) |=> ($stable(cnt) && $stable(ena)))
        else $error("write to unmapped offset changed state");

endmodule

// File: tb/ctmr_top_test.sv
`timescale 1ns/1ps
module ctmr_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_cnt = 0;
    int m_cause = 0;
    int m_ena = 0;
    int taps[4] = '{2, 4, 6, 7};

    always #2.5 clk = ~clk;

    ctmr_top uut (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string tg, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tg, act, exp);
        end
    endtask

    function automatic int exp_read(input int a);
        case (a)
            0: return m_cause;
            1: return m_ena;
            2: return m_cnt % 16;
            3: return m_cnt / 16;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(input int a);
        case (a)
            0: return "R7";
            1: return "R8";
            2, 3: return "R2";
            4: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic model_update(input bit t, input bit r, input bit w, input int a, input int d);
        int nc = m_cnt;
        int falls = 0;
        if (w && a == 4 && (d % 2) == 1) begin
            nc = 0;
        end else if (t) begin
            nc = (m_cnt + 1) % 256;
            for (int k = 0; k < 4; k++) begin
                if (((m_cnt >> taps[k]) & 1) == 1 && ((nc >> taps[k]) & 1) == 0)
                    falls |= (1 << k);
            end
        end
        if (r && a == 0) m_cause = falls;
        else m_cause |= falls;
        if (w && a == 1) m_ena = d % 16;
        m_cnt = nc;
    endtask

    task automatic step(input bit t, input bit r, input bit w, input int a, input int d,
                        input string tg = "");
        @(negedge clk);
        tick = t; rd_en = r; wr_en = w; addr = a[3:0]; wdata = d[3:0];
        #1;
        if (r) check((tg == "") ? tag_for(a) : tg, rdata, 4'(exp_read(a)));
        else check("R10", rdata, 4'd0);
        check("R9", {3'b0, irq}, {3'b0, ((m_cause & m_ena) != 0)});
        @(posedge clk);
        model_update(t, r, w, a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and irq
        for (int a = 0; a < 5; a++) step(0, 1, 0, a, 0, "R1");

        // R8: enable register read/write
        step(0, 0, 1, 1, 4'hA);
        step(0, 1, 0, 1, 0, "R8");
        step(0, 0, 1, 1, 4'hF);
        step(0, 1, 0, 1, 0, "R8");

        // R2, R6, R7, R9: long run covering every tap and the wrap at 255
        for (int i = 0; i < 700; i++) begin
            bit t = (i % 7) != 3;
            bit r = (i % 3) == 0;
            step(t, r, 0, (i / 3) % 6, 0);
        end

        // R5: writes to counter nibbles are ignored
        step(0, 1, 0, 2, 0, "R5");
        step(0, 0, 1, 2, 4'hF);
        step(0, 0, 1, 3, 4'hF);
        step(0, 1, 0, 2, 0, "R5");
        step(0, 1, 0, 3, 0, "R5");

        // R3: writing 0 to the clear bit does nothing, writing 1 wins over tick
        step(1, 0, 1, 4, 4'hE);
        step(0, 1, 0, 2, 0, "R3");
        step(0, 1, 0, 3, 0, "R3");
        step(1, 0, 1, 4, 4'h1);
        step(0, 1, 0, 2, 0, "R3");
        step(0, 1, 0, 3, 0, "R3");

        // R7: read of cause register in the same cycle the 32 Hz tap falls
        step(0, 1, 0, 0, 0, "R7");
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
        step(0, 1, 0, 2, 0, "R2");
        step(1, 1, 0, 0, 0, "R7");
        step(0, 1, 0, 0, 0, "R7");

        // R6, R9: flags set while masked, irq follows enables
        step(0, 0, 1, 1, 4'h0);
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 1, 4'h1);
        step(0, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 1, 1, 4'h2);
        step(0, 0, 0, 0, 0, "R9");

        // R10: unmapped offsets read 0 and ignore writes
        for (int a = 5; a < 16; a++) begin
            step(0, 0, 1, a, 4'hF);
            step(0, 1, 0, a, 0, "R10");
        end
        step(0, 1, 0, 1, 0, "R10");
        step(0, 1, 0, 2, 0, "R10");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule